// File: doc/BRIEF.md
# SMBus Target Transaction Sequencer

This block sits on top of a byte-level I2C target engine and turns that engine's event pulses into SMBus transactions. The engine reports a start addressed for writing, a start addressed for reading, a stop, and a NACK from the controller. It also hands over each byte written by the controller and asks for a byte whenever the controller reads. The sequencer collects written bytes in a buffer, and the first buffered byte is the command code. It passes the result on to a backend in one of three forms: a quick-command strobe with a direction bit, a commit strobe with the whole buffer and its length, or a byte fetch from a valid/pop byte port.

Rule-breaking sequences send the sequencer to an error state. It leaves that state only on the next stop. Overflow of the buffer, stray writes and a stop that arrives while a read is still under way are each reported as a single-cycle flag. The engine is expected to present at most one event, write or read request per cycle. If several arrive together, the order of precedence is stop, write-start, read-start, NACK, read request, written byte.

Top module: `smbus_txn_seq`

## Requirements
- R1: After reset, busy, in_error, rd_valid, commit_stb, quick_stb, bad_stop, wr_overflow, wr_stray and be_pop are all 0.
- R2: A write-start in idle enters the write phase (busy=1). A write-start in any other state enters the error state (in_error=1, busy=1).
- R3: A read-start in idle enters the read phase directly, and no commit is issued.
- R4: A read-start in the write phase with at least one buffered byte pulses commit_stb with the buffered length and data, then enters the read phase. With zero buffered bytes it enters the error state. A read-start in the read, done or error state also enters the error state.
- R5: A stop with zero buffered bytes pulses quick_stb if the state was the write phase (quick_dir=0) or the read phase (quick_dir=1). A stop with zero bytes in the done or error state pulses nothing.
- R6: A stop in the write phase with buffered bytes pulses commit_stb. commit_len is the byte count. Byte i of the transfer sits at commit_data[8i+7:8i], so the command code is at bits 7:0.
- R7: A stop in the read phase with a nonzero byte count (left over from a write before a repeated start) pulses bad_stop and issues no commit or quick strobe.
- R8: Every stop returns the sequencer to idle (busy=0, in_error=0) and clears the byte count, from any state including error.
- R9: A NACK in the read phase enters the done state. A NACK in done changes nothing. A NACK in idle, the write phase or error enters the error state.
- R10: A read request in the read phase returns be_byte and pulses be_pop when be_valid is 1, and returns 0xFF without be_pop when be_valid is 0. In any other state it returns 0xFF and enters the error state. rd_valid marks every answer.
- R11: In the write phase, bytes beyond BUF_DEPTH are dropped and each one pulses wr_overflow. A later commit reports length BUF_DEPTH and the first BUF_DEPTH bytes.
- R12: A written byte outside the write phase pulses wr_stray and is not stored.
- R13: Every output is a register updated on the clock edge that samples the stimulus. All strobes and flags last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start_wr | input | 1 | Start addressed for writing (pulse) |
| ev_start_rd | input | 1 | Start addressed for reading (pulse) |
| ev_stop | input | 1 | Stop condition (pulse) |
| ev_nack | input | 1 | Controller NACKed a read byte (pulse) |
| wr_valid | input | 1 | Written byte present |
| wr_byte | input | 8 | Written byte |
| rd_req | input | 1 | Engine requests a read byte |
| be_valid | input | 1 | Backend has a byte ready |
| be_byte | input | 8 | Backend byte |
| be_pop | output | 1 | Backend byte was consumed |
| rd_valid | output | 1 | rd_data answers the last request |
| rd_data | output | 8 | Byte returned to the engine |
| commit_stb | output | 1 | Buffered write committed |
| commit_len | output | LEN_W | Committed byte count |
| commit_data | output | 8*BUF_DEPTH | Buffer contents, byte i at bits 8i+7:8i |
| quick_stb | output | 1 | Quick command |
| quick_dir | output | 1 | Quick command direction, 1 = read |
| bad_stop | output | 1 | Stop during a read with bytes counted |
| wr_overflow | output | 1 | Written byte dropped, buffer full |
| wr_stray | output | 1 | Written byte outside the write phase |
| busy | output | 1 | State is not idle |
| in_error | output | 1 | State is error |

## Verification
Each result is due exactly one clock after the edge that samples its stimulus: the strobes, flags, rd_data/rd_valid and the busy/in_error state all come out of a single register stage. The bench drives each stimulus on a falling edge, lets one rising edge pass and compares every output on the following falling edge. It then clears the inputs, so a strobe that lingered for a second cycle would show up as a mismatch on the next step. The commit data bytes are compared only in the cycle commit_stb is high, up to the committed length.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WRITE = 3'd1,
    ST_READ  = 3'd2,
    ST_DONE  = 3'd3,
    ST_ERR   = 3'd4
  } seq_state_t;

  localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/smbus_seq_buf.sv
module smbus_seq_buf #(
  parameter int DEPTH = 34,
  parameter int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 push,
  input  logic [7:0]           din,
  output logic [LEN_W-1:0]     count,
  output logic                 full,
  output logic [8*DEPTH-1:0]   data_flat
);
  logic [LEN_W-1:0] count_nxt;
  logic             take;

  assign full = (count == LEN_W'(DEPTH));
  assign take = push && !full && !clr;

  always_comb begin
    count_nxt = count;
    if (clr)       count_nxt = '0;
    else if (take) count_nxt = count + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic slot_en;
    assign slot_en = take && (count == LEN_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_flat[8*gi +: 8] <= '0;
      else if (slot_en) data_flat[8*gi +: 8] <= din;
    end
  end

  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LEN_W'(DEPTH));
  a_r11_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !clr) |=> $stable(count));
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/smbus_seq_ctrl.sv
module smbus_seq_ctrl
  import smbus_seq_pkg::*;
#(
  parameter int DEPTH = 34,
  parameter int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start_wr,
  input  logic             ev_start_rd,
  input  logic             ev_stop,
  input  logic             ev_nack,
  input  logic             wr_valid,
  input  logic             rd_req,
  input  logic             be_valid,
  input  logic [7:0]       be_byte,
  input  logic [LEN_W-1:0] count,
  input  logic             full,
  output logic             buf_clr,
  output logic             buf_push,
  output logic             be_pop,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             commit_stb,
  output logic [LEN_W-1:0] commit_len,
  output logic             quick_stb,
  output logic             quick_dir,
  output logic             bad_stop,
  output logic             wr_overflow,
  output logic             wr_stray,
  output logic             busy,
  output logic             in_error
);
  seq_state_t       st, st_nxt;
  logic             commit_n, quick_n, qdir_n, badstop_n, ovf_n, stray_n;
  logic             pop_n, rdv_n;
  logic [7:0]       rdd_n;
  logic [LEN_W-1:0] clen_n;
  logic             no_bytes;

  assign no_bytes = (count == '0);

  always_comb begin
    st_nxt    = st;
    commit_n  = 1'b0;
    quick_n   = 1'b0;
    qdir_n    = quick_dir;
    badstop_n = 1'b0;
    ovf_n     = 1'b0;
    stray_n   = 1'b0;
    pop_n     = 1'b0;
    rdv_n     = 1'b0;
    rdd_n     = rd_data;
    buf_clr   = 1'b0;
    buf_push  = 1'b0;
    if (ev_stop) begin
      buf_clr = 1'b1;
      st_nxt  = ST_IDLE;
      if (no_bytes) begin
        if (st == ST_WRITE || st == ST_READ) begin
          quick_n = 1'b1;
          qdir_n  = (st == ST_READ);
        end
      end else if (st == ST_WRITE) begin
        commit_n = 1'b1;
      end else if (st == ST_READ) begin
        badstop_n = 1'b1;
      end
    end else if (ev_start_wr) begin
      st_nxt = (st == ST_IDLE) ? ST_WRITE : ST_ERR;
    end else if (ev_start_rd) begin
      if (st == ST_IDLE) begin
        st_nxt = ST_READ;
      end else if (st == ST_WRITE && !no_bytes) begin
        commit_n = 1'b1;
        st_nxt   = ST_READ;
      end else begin
        st_nxt = ST_ERR;
      end
    end else if (ev_nack) begin
      if (st == ST_READ)      st_nxt = ST_DONE;
      else if (st != ST_DONE) st_nxt = ST_ERR;
    end else if (rd_req) begin
      rdv_n = 1'b1;
      rdd_n = IDLE_BYTE;
      if (st == ST_READ) begin
        if (be_valid) begin
          rdd_n = be_byte;
          pop_n = 1'b1;
        end
      end else begin
        st_nxt = ST_ERR;
      end
    end else if (wr_valid) begin
      if (st == ST_WRITE) begin
        if (full) ovf_n    = 1'b1;
        else      buf_push = 1'b1;
      end else begin
        stray_n = 1'b1;
      end
    end
    clen_n = commit_n ? count : commit_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      commit_stb  <= 1'b0;
      commit_len  <= '0;
      quick_stb   <= 1'b0;
      quick_dir   <= 1'b0;
      bad_stop    <= 1'b0;
      wr_overflow <= 1'b0;
      wr_stray    <= 1'b0;
      be_pop      <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= IDLE_BYTE;
      busy        <= 1'b0;
      in_error    <= 1'b0;
    end else begin
      st          <= st_nxt;
      commit_stb  <= commit_n;
      commit_len  <= clen_n;
      quick_stb   <= quick_n;
      quick_dir   <= qdir_n;
      bad_stop    <= badstop_n;
      wr_overflow <= ovf_n;
      wr_stray    <= stray_n;
      be_pop      <= pop_n;
      rd_valid    <= rdv_n;
      rd_data     <= rdd_n;
      busy        <= (st_nxt != ST_IDLE);
      in_error    <= (st_nxt == ST_ERR);
    end
  end

  a_r4_commit_len: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |-> (commit_len != '0 && commit_len <= LEN_W'(DEPTH)));
  a_r5_quick_alone: assert property (@(posedge clk) disable iff (!rst_n)
    quick_stb |-> (!commit_stb && !bad_stop));
  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!busy && !in_error));
  a_r9_nack_done: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_nack && st == ST_READ && !ev_stop && !ev_start_wr && !ev_start_rd) |=> (st == ST_DONE));
  a_r10_pop_answer: assert property (@(posedge clk) disable iff (!rst_n)
    be_pop |-> rd_valid);
  a_r13_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |=> !commit_stb);
  a_r2_err_busy: assert property (@(posedge clk) disable iff (!rst_n)
    in_error |-> busy);
endmodule

// File: rtl/smbus_txn_seq.sv
module smbus_txn_seq #(
  parameter int BUF_DEPTH = 34,
  parameter int LEN_W     = $clog2(BUF_DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ev_start_wr,
  input  logic                   ev_start_rd,
  input  logic                   ev_stop,
  input  logic                   ev_nack,
  input  logic                   wr_valid,
  input  logic [7:0]             wr_byte,
  input  logic                   rd_req,
  input  logic                   be_valid,
  input  logic [7:0]             be_byte,
  output logic                   be_pop,
  output logic                   rd_valid,
  output logic [7:0]             rd_data,
  output logic                   commit_stb,
  output logic [LEN_W-1:0]       commit_len,
  output logic [8*BUF_DEPTH-1:0] commit_data,
  output logic                   quick_stb,
  output logic                   quick_dir,
  output logic                   bad_stop,
  output logic                   wr_overflow,
  output logic                   wr_stray,
  output logic                   busy,
  output logic                   in_error
);
  logic             buf_clr, buf_push, buf_full;
  logic [LEN_W-1:0] buf_count;

  smbus_seq_buf #(.DEPTH(BUF_DEPTH), .LEN_W(LEN_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (buf_clr),
    .push      (buf_push),
    .din       (wr_byte),
    .count     (buf_count),
    .full      (buf_full),
    .data_flat (commit_data)
  );

  smbus_seq_ctrl #(.DEPTH(BUF_DEPTH), .LEN_W(LEN_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_start_wr (ev_start_wr),
    .ev_start_rd (ev_start_rd),
    .ev_stop     (ev_stop),
    .ev_nack     (ev_nack),
    .wr_valid    (wr_valid),
    .rd_req      (rd_req),
    .be_valid    (be_valid),
    .be_byte     (be_byte),
    .count       (buf_count),
    .full        (buf_full),
    .buf_clr     (buf_clr),
    .buf_push    (buf_push),
    .be_pop      (be_pop),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .commit_stb  (commit_stb),
    .commit_len  (commit_len),
    .quick_stb   (quick_stb),
    .quick_dir   (quick_dir),
    .bad_stop    (bad_stop),
    .wr_overflow (wr_overflow),
    .wr_stray    (wr_stray),
    .busy        (busy),
    .in_error    (in_error)
  );

  a_r12_stray_not_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stray |-> !(wr_overflow || commit_stb));
endmodule

// File: tb/smbus_txn_seq_test.sv
module smbus_txn_seq_test;
  localparam int D = 34;
  localparam int LW = $clog2(D + 1);
  localparam int OP_SW = 0, OP_SR = 1, OP_STOP = 2, OP_NACK = 3, OP_RD = 4, OP_WR = 5, OP_NOP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_start_wr = 0, ev_start_rd = 0, ev_stop = 0, ev_nack = 0;
  logic wr_valid = 0, rd_req = 0, be_valid = 0;
  logic [7:0] wr_byte = 0, be_byte = 0;
  logic be_pop, rd_valid, commit_stb, quick_stb, quick_dir, bad_stop;
  logic wr_overflow, wr_stray, busy, in_error;
  logic [7:0] rd_data;
  logic [LW-1:0] commit_len;
  logic [8*D-1:0] commit_data;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  smbus_txn_seq #(.BUF_DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .ev_start_wr(ev_start_wr), .ev_start_rd(ev_start_rd),
    .ev_stop(ev_stop), .ev_nack(ev_nack), .wr_valid(wr_valid), .wr_byte(wr_byte),
    .rd_req(rd_req), .be_valid(be_valid), .be_byte(be_byte), .be_pop(be_pop),
    .rd_valid(rd_valid), .rd_data(rd_data), .commit_stb(commit_stb),
    .commit_len(commit_len), .commit_data(commit_data), .quick_stb(quick_stb),
    .quick_dir(quick_dir), .bad_stop(bad_stop), .wr_overflow(wr_overflow),
    .wr_stray(wr_stray), .busy(busy), .in_error(in_error)
  );

  // reference model: 0 idle, 1 write, 2 read, 3 done, 4 error
  int m_st = 0, m_cnt = 0;
  logic [7:0] m_buf [D];
  logic e_commit, e_quick, e_qdir, e_bst, e_ovf, e_stray, e_pop, e_rdv;
  logic [7:0] e_rdd;
  logic [LW-1:0] e_len;

  function automatic string tag_of(int op);
    case (op)
      OP_SW:   return "R2";
      OP_SR:   return "R4";
      OP_STOP: return "R8";
      OP_NACK: return "R9";
      OP_RD:   return "R10";
      OP_WR:   return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic model(int op, logic [7:0] b, logic bv, logic [7:0] bb);
    e_commit = 0; e_quick = 0; e_bst = 0; e_ovf = 0; e_stray = 0; e_pop = 0; e_rdv = 0;
    case (op)
      OP_STOP: begin
        if (m_cnt == 0) begin
          if (m_st == 1 || m_st == 2) begin e_quick = 1; e_qdir = (m_st == 2); end
        end else if (m_st == 1) begin e_commit = 1; e_len = LW'(m_cnt); end
        else if (m_st == 2) e_bst = 1;
        m_st = 0; m_cnt = 0;
      end
      OP_SW: m_st = (m_st == 0) ? 1 : 4;
      OP_SR: begin
        if (m_st == 0) m_st = 2;
        else if (m_st == 1 && m_cnt > 0) begin e_commit = 1; e_len = LW'(m_cnt); m_st = 2; end
        else m_st = 4;
      end
      OP_NACK: begin
        if (m_st == 2) m_st = 3;
        else if (m_st != 3) m_st = 4;
      end
      OP_RD: begin
        e_rdv = 1; e_rdd = 8'hFF;
        if (m_st == 2) begin
          if (bv) begin e_rdd = bb; e_pop = 1; end
        end else m_st = 4;
      end
      OP_WR: begin
        if (m_st == 1) begin
          if (m_cnt == D) e_ovf = 1;
          else begin m_buf[m_cnt] = b; m_cnt++; end
        end else e_stray = 1;
      end
      default: ;
    endcase
  endtask

  task automatic check(string tag);
    logic data_ok;
    logic [25:0] act, exp;
    data_ok = 1'b1;
    if (e_commit)
      for (int i = 0; i < int'(e_len); i++)
        if (commit_data[8*i +: 8] !== m_buf[i]) data_ok = 1'b0;
    act = {commit_stb, (commit_stb ? commit_len : LW'(0)), quick_stb, quick_dir, bad_stop,
           wr_overflow, wr_stray, be_pop, rd_valid, rd_data, busy, in_error, data_ok};
    exp = {e_commit, (e_commit ? e_len : LW'(0)), e_quick, e_qdir, e_bst,
           e_ovf, e_stray, e_pop, e_rdv, e_rdd, (m_st != 0), (m_st == 4), 1'b1};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(int op, logic [7:0] b, logic bv, logic [7:0] bb, string tag);
    ev_start_wr = (op == OP_SW); ev_start_rd = (op == OP_SR);
    ev_stop = (op == OP_STOP); ev_nack = (op == OP_NACK);
    rd_req = (op == OP_RD); wr_valid = (op == OP_WR);
    wr_byte = b; be_valid = bv; be_byte = bb;
    model(op, b, bv, bb);
    @(posedge clk);
    @(negedge clk);
    check(tag);
    ev_start_wr = 0; ev_start_rd = 0; ev_stop = 0; ev_nack = 0;
    rd_req = 0; wr_valid = 0; be_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    e_qdir = 0; e_rdd = 8'hFF; e_len = '0;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model(OP_NOP, 0, 0, 0);
    check("R1");
    // R6: write commit at stop, command code first
    step(OP_SW, 0, 0, 0, "R2");
    step(OP_WR, 8'h3C, 0, 0, "R6");
    step(OP_WR, 8'hA5, 0, 0, "R6");
    step(OP_STOP, 0, 0, 0, "R6");
    // R5 quick write and read
    step(OP_SW, 0, 0, 0, "R2");
    step(OP_STOP, 0, 0, 0, "R5");
    step(OP_SR, 0, 0, 0, "R3");
    step(OP_STOP, 0, 0, 0, "R5");
    // R4 combined: write cmd, repeated start, read, nack, stop
    step(OP_SW, 0, 0, 0, "R2");
    step(OP_WR, 8'h11, 0, 0, "R4");
    step(OP_SR, 0, 0, 0, "R4");
    step(OP_RD, 0, 1, 8'h5A, "R10");
    step(OP_RD, 0, 0, 8'h00, "R10");
    step(OP_NACK, 0, 0, 0, "R9");
    step(OP_NACK, 0, 0, 0, "R9");
    step(OP_STOP, 0, 0, 0, "R8");
    // R7 stop during read with bytes counted
    step(OP_SW, 0, 0, 0, "R2");
    step(OP_WR, 8'h22, 0, 0, "R7");
    step(OP_SR, 0, 0, 0, "R4");
    step(OP_STOP, 0, 0, 0, "R7");
    // R4 zero-byte repeated start is error; R8 stop leaves error
    step(OP_SW, 0, 0, 0, "R2");
    step(OP_SR, 0, 0, 0, "R4");
    step(OP_RD, 0, 1, 8'h77, "R10");
    step(OP_STOP, 0, 0, 0, "R8");
    // R12 stray write then R9 nack in idle
    step(OP_WR, 8'h99, 0, 0, "R12");
    step(OP_NACK, 0, 0, 0, "R9");
    step(OP_STOP, 0, 0, 0, "R5");
    // R11 overflow
    step(OP_SW, 0, 0, 0, "R2");
    for (int i = 0; i < D + 3; i++) step(OP_WR, 8'(i * 7 + 1), 0, 0, "R11");
    step(OP_STOP, 0, 0, 0, "R11");
    // R2 start-write while busy
    step(OP_SR, 0, 0, 0, "R3");
    step(OP_SW, 0, 0, 0, "R2");
    step(OP_STOP, 0, 0, 0, "R8");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r, op;
      r = int'($urandom % 16);
      if (r < 6) op = OP_WR;
      else if (r < 8) op = OP_RD;
      else if (r < 10) op = OP_SW;
      else if (r < 12) op = OP_SR;
      else if (r < 13) op = OP_STOP;
      else if (r < 14) op = OP_NACK;
      else op = OP_NOP;
      step(op, 8'($urandom), 1'($urandom), 8'($urandom), tag_of(op));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule